// File: doc/BRIEF.md
# Dual-Endian Instruction Decoder

This block turns a stream of 64-bit instruction slots for a small 64-bit register machine into decoded control fields. Each accepted slot yields one registered record. The record holds the class, the operation and source-select subfields, the load/store mode and size subfields, both register numbers, the signed offset, a 64-bit immediate and three flags: a double-slot record, an illegal encoding, and a truncated instruction.

A static mode input selects little-endian or big-endian slot layout. The mode decides which nibble of the register byte names the destination. It also decides the byte order used to assemble the offset and the immediate. One code value, the wide immediate load, occupies two consecutive slots. The decoder swallows the first slot and emits a single merged record when the second slot arrives. A per-slot end-of-stream marker lets the decoder report a wide load that has lost its second half.

Slots enter through a valid/ready handshake. Decoded records leave through a second valid/ready handshake. A record stays on the outputs until the consumer takes it.

Top module: `dual_endian_decoder`

## Requirements
- R1: While reset is held and after it is released, `dec_valid_o` is 0 and `slot_ready_o` is 1.
- R2: In little-endian mode (`big_endian_i`=0) the layout is as follows, with slot byte k at bits 8k+7:8k. Byte 0 is the code. Destination is byte 1 bits 3:0 and source is byte 1 bits 7:4. Offset is {byte3,byte2}. The 32-bit immediate is {byte7,byte6,byte5,byte4}, sign-extended to 64 bits on `dec_imm_o`.
- R3: In big-endian mode destination is byte 1 bits 7:4 and source is byte 1 bits 3:0. Offset is {byte2,byte3} and the immediate is {byte4,byte5,byte6,byte7}, sign-extended.
- R4: The code byte is split into the following outputs, all presented on every record:
  - `dec_op_o` = code[7:4]
  - `dec_srcsel_o` = code[3]
  - `dec_class_o` = code[2:0]
  - `dec_mode_o` = code[7:5]
  - `dec_size_o` = code[4:3]
- R5: Class 3'b110 is illegal. For the arithmetic classes 3'b100 and 3'b111 and the jump class 3'b101, operation values 4'hE and 4'hF are illegal.
- R6: For the load/store classes, mode values 3'b100, 3'b101 and 3'b111 are illegal. The legal combinations are:
  - class 3'b000 takes mode 3'b000 only with size 2'b11, or modes 3'b001 and 3'b010;
  - classes 3'b001 and 3'b010 take only mode 3'b011;
  - class 3'b011 takes modes 3'b011 and 3'b110.
- R7: Mode 3'b110 (atomic add to memory) is legal only in class 3'b011 and only with size 2'b00 or 2'b11.
- R8: Code 8'h18 in a slot that is not marked last opens a wide load, and that slot produces no record. The next accepted slot completes it. The merged record carries the code, registers and offset of the first slot, and `dec_wide_o`=1. Its immediate is {second slot immediate, first slot immediate}, both read in the selected byte order.
- R9: If any of bytes 0..3 of the second slot of a wide load is nonzero, the merged record has `dec_illegal_o`=1.
- R10: Code 8'h18 in a slot accepted with `slot_last_i`=1 yields at once a record with `dec_trunc_o`=1 and `dec_wide_o`=1. That record carries the sign-extended first-slot immediate. The next slot then decodes as the start of a new instruction.
- R11: A slot accepted at a clock edge gives its record, with `dec_valid_o`=1, right after that edge. While `dec_valid_o`=1 and `dec_ready_i`=0, every output holds and `slot_ready_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| big_endian_i | input | 1 | Static layout mode, 1 = big-endian |
| slot_valid_i | input | 1 | Slot present |
| slot_data_i | input | 64 | Instruction slot, byte k at bits 8k+7:8k |
| slot_last_i | input | 1 | Slot is the last of the stream |
| slot_ready_o | output | 1 | Decoder can take a slot |
| dec_valid_o | output | 1 | Decoded record present |
| dec_ready_i | input | 1 | Consumer takes the record |
| dec_class_o | output | 3 | Instruction class |
| dec_op_o | output | 4 | Operation subfield |
| dec_srcsel_o | output | 1 | Source select, 1 = register |
| dec_mode_o | output | 3 | Load/store mode subfield |
| dec_size_o | output | 2 | Load/store size subfield |
| dec_dst_o | output | 4 | Destination register |
| dec_src_o | output | 4 | Source register |
| dec_off_o | output | 16 | Signed offset |
| dec_imm_o | output | 64 | Immediate, sign-extended or merged |
| dec_wide_o | output | 1 | Record came from a double-slot load |
| dec_illegal_o | output | 1 | Illegal encoding |
| dec_trunc_o | output | 1 | Wide load cut off by end of stream |

## Verification
The end-of-stream marker and the opening half of a wide load can land on the same slot. The decoder must then turn a would-be pending state into an immediate truncation record rather than waiting for a slot that never comes. The bench provokes this by sending code 8'h18 with `slot_last_i` high. It judges the record's truncation, wide and immediate fields. It then sends an ordinary slot and expects a plain single-slot record.

A second collision is a new slot offered while a record is held under backpressure. The bench checks that the slot is refused and the held record does not move. It then checks that the slot is taken in the very cycle the consumer accepts.

// File: rtl/ede_pkg.sv
package ede_pkg;
    localparam int SLOT_W    = 64;
    localparam int BYTE_W    = 8;
    localparam int NUM_BYTES = SLOT_W / BYTE_W;
    localparam int CODE_W    = 8;
    localparam int REG_W     = 4;
    localparam int OFF_W     = 16;
    localparam int IMM_W     = 32;
    localparam int WIDE_W    = 2 * IMM_W;
    localparam int OFF_BASE  = 2;
    localparam int IMM_BASE  = 4;
    localparam int OFF_B     = OFF_W / BYTE_W;
    localparam int IMM_B     = IMM_W / BYTE_W;

    localparam logic [2:0] CL_LD    = 3'b000;
    localparam logic [2:0] CL_LDX   = 3'b001;
    localparam logic [2:0] CL_ST    = 3'b010;
    localparam logic [2:0] CL_STX   = 3'b011;
    localparam logic [2:0] CL_ALU   = 3'b100;
    localparam logic [2:0] CL_JMP   = 3'b101;
    localparam logic [2:0] CL_ALU64 = 3'b111;

    localparam logic [2:0] MD_IMM  = 3'b000;
    localparam logic [2:0] MD_ABS  = 3'b001;
    localparam logic [2:0] MD_IND  = 3'b010;
    localparam logic [2:0] MD_MEM  = 3'b011;
    localparam logic [2:0] MD_ATOM = 3'b110;

    localparam logic [1:0] SZ_4 = 2'b00;
    localparam logic [1:0] SZ_8 = 2'b11;

    localparam logic [3:0]        OP_MAX    = 4'hD;
    localparam logic [CODE_W-1:0] WIDE_CODE = 8'h18;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [REG_W-1:0]  dst;
        logic [REG_W-1:0]  src;
        logic [OFF_W-1:0]  off;
        logic [WIDE_W-1:0] imm;
        logic              wide;
        logic              illegal;
        logic              trunc;
    } dec_rec_t;

    typedef struct packed {
        logic     out_valid;
        dec_rec_t out;
        logic     pend;
        dec_rec_t hold;
    } dec_state_t;
endpackage

// File: rtl/ede_fields.sv
module ede_fields
    import ede_pkg::*;
(
    input  logic [SLOT_W-1:0] slot_i,
    input  logic              big_endian_i,
    output logic [CODE_W-1:0] code_o,
    output logic [REG_W-1:0]  dst_o,
    output logic [REG_W-1:0]  src_o,
    output logic [OFF_W-1:0]  off_o,
    output logic [IMM_W-1:0]  imm_o,
    output logic              head_zero_o
);
    logic [NUM_BYTES-1:0][BYTE_W-1:0] bytes_w;
    logic [OFF_W-1:0] off_le, off_be;
    logic [IMM_W-1:0] imm_le, imm_be;
    logic [BYTE_W-1:0] regs_w;

    assign bytes_w = slot_i;
    assign code_o  = bytes_w[0];
    assign regs_w  = bytes_w[1];

    // byte-order assembly of the offset field
    for (genvar g = 0; g < OFF_B; g++) begin : g_off
        assign off_le[g*BYTE_W +: BYTE_W] = bytes_w[OFF_BASE + g];
        assign off_be[g*BYTE_W +: BYTE_W] = bytes_w[OFF_BASE + OFF_B - 1 - g];
    end

    // byte-order assembly of the immediate field
    for (genvar g = 0; g < IMM_B; g++) begin : g_imm
        assign imm_le[g*BYTE_W +: BYTE_W] = bytes_w[IMM_BASE + g];
        assign imm_be[g*BYTE_W +: BYTE_W] = bytes_w[IMM_BASE + IMM_B - 1 - g];
    end

    assign dst_o       = big_endian_i ? regs_w[2*REG_W-1:REG_W] : regs_w[REG_W-1:0];
    assign src_o       = big_endian_i ? regs_w[REG_W-1:0] : regs_w[2*REG_W-1:REG_W];
    assign off_o       = big_endian_i ? off_be : off_le;
    assign imm_o       = big_endian_i ? imm_be : imm_le;
    assign head_zero_o = (slot_i[IMM_BASE*BYTE_W-1:0] == '0);
endmodule

// File: rtl/ede_legal.sv
module ede_legal
    import ede_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic              illegal_o,
    output logic              wide_start_o
);
    logic [2:0] cls_w, mode_w;
    logic [3:0] op_w;
    logic [1:0] size_w;

    assign cls_w  = code_i[2:0];
    assign op_w   = code_i[7:4];
    assign mode_w = code_i[7:5];
    assign size_w = code_i[4:3];

    always_comb begin
        illegal_o = 1'b1;
        unique case (cls_w)
            CL_LD: begin
                if (mode_w == MD_IMM)                          illegal_o = (size_w != SZ_8);
                else if (mode_w == MD_ABS || mode_w == MD_IND) illegal_o = 1'b0;
            end
            CL_LDX, CL_ST: illegal_o = (mode_w != MD_MEM);
            CL_STX: begin
                if (mode_w == MD_MEM)       illegal_o = 1'b0;
                else if (mode_w == MD_ATOM) illegal_o = !(size_w == SZ_4 || size_w == SZ_8);
            end
            CL_ALU, CL_JMP, CL_ALU64: illegal_o = (op_w > OP_MAX);
            default: illegal_o = 1'b1;
        endcase
    end

    assign wide_start_o = (code_i == WIDE_CODE);
endmodule

// File: rtl/dual_endian_decoder.sv
module dual_endian_decoder
    import ede_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              big_endian_i,
    input  logic              slot_valid_i,
    input  logic [SLOT_W-1:0] slot_data_i,
    input  logic              slot_last_i,
    output logic              slot_ready_o,
    output logic              dec_valid_o,
    input  logic              dec_ready_i,
    output logic [2:0]        dec_class_o,
    output logic [3:0]        dec_op_o,
    output logic              dec_srcsel_o,
    output logic [2:0]        dec_mode_o,
    output logic [1:0]        dec_size_o,
    output logic [REG_W-1:0]  dec_dst_o,
    output logic [REG_W-1:0]  dec_src_o,
    output logic [OFF_W-1:0]  dec_off_o,
    output logic [WIDE_W-1:0] dec_imm_o,
    output logic              dec_wide_o,
    output logic              dec_illegal_o,
    output logic              dec_trunc_o
);
    dec_state_t st_d, st_q;

    logic [CODE_W-1:0] code_w;
    logic [REG_W-1:0]  dst_w, src_w;
    logic [OFF_W-1:0]  off_w;
    logic [IMM_W-1:0]  imm_w;
    logic              head_zero_w, illegal_w, wide_start_w, take_w;
    dec_rec_t          cur_rec;

    ede_fields u_fields (
        .slot_i      (slot_data_i),
        .big_endian_i(big_endian_i),
        .code_o      (code_w),
        .dst_o       (dst_w),
        .src_o       (src_w),
        .off_o       (off_w),
        .imm_o       (imm_w),
        .head_zero_o (head_zero_w)
    );

    ede_legal u_legal (
        .code_i      (code_w),
        .illegal_o   (illegal_w),
        .wide_start_o(wide_start_w)
    );

    // single-slot view of the incoming slot
    always_comb begin
        cur_rec         = '0;
        cur_rec.code    = code_w;
        cur_rec.dst     = dst_w;
        cur_rec.src     = src_w;
        cur_rec.off     = off_w;
        cur_rec.imm     = {{(WIDE_W-IMM_W){imm_w[IMM_W-1]}}, imm_w};
        cur_rec.illegal = illegal_w;
    end

    assign slot_ready_o = !st_q.out_valid || dec_ready_i;
    assign take_w       = slot_valid_i && slot_ready_o;

    always_comb begin
        st_d = st_q;
        if (st_q.out_valid && dec_ready_i) begin
            st_d.out_valid = 1'b0;
        end
        if (take_w) begin
            if (st_q.pend) begin
                // second half of a wide load
                st_d.pend        = 1'b0;
                st_d.out         = st_q.hold;
                st_d.out.imm     = {imm_w, st_q.hold.imm[IMM_W-1:0]};
                st_d.out.wide    = 1'b1;
                st_d.out.illegal = !head_zero_w;
                st_d.out.trunc   = 1'b0;
                st_d.out_valid   = 1'b1;
            end else if (wide_start_w && slot_last_i) begin
                st_d.out       = cur_rec;
                st_d.out.wide  = 1'b1;
                st_d.out.trunc = 1'b1;
                st_d.out_valid = 1'b1;
            end else if (wide_start_w) begin
                st_d.pend = 1'b1;
                st_d.hold = cur_rec;
            end else begin
                st_d.out       = cur_rec;
                st_d.out_valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign dec_valid_o   = st_q.out_valid;
    assign dec_class_o   = st_q.out.code[2:0];
    assign dec_op_o      = st_q.out.code[7:4];
    assign dec_srcsel_o  = st_q.out.code[3];
    assign dec_mode_o    = st_q.out.code[7:5];
    assign dec_size_o    = st_q.out.code[4:3];
    assign dec_dst_o     = st_q.out.dst;
    assign dec_src_o     = st_q.out.src;
    assign dec_off_o     = st_q.out.off;
    assign dec_imm_o     = st_q.out.imm;
    assign dec_wide_o    = st_q.out.wide;
    assign dec_illegal_o = st_q.out.illegal;
    assign dec_trunc_o   = st_q.out.trunc;
endmodule

// File: rtl/ede_checker.sv
module ede_checker
    import ede_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              slot_ready_o,
    input logic              dec_valid_o,
    input logic              dec_ready_i,
    input logic [2:0]        dec_class_o,
    input logic [2:0]        dec_mode_o,
    input logic [1:0]        dec_size_o,
    input logic [REG_W-1:0]  dec_dst_o,
    input logic [WIDE_W-1:0] dec_imm_o,
    input logic              dec_wide_o,
    input logic              dec_illegal_o,
    input logic              dec_trunc_o
);
    AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec_valid_o && !dec_ready_i) |=> (dec_valid_o && $stable(dec_imm_o) && $stable(dec_dst_o))); // R11

    AST_STALL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec_valid_o && !dec_ready_i) |-> !slot_ready_o); // R11

    AST_TRUNC_IS_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec_valid_o && dec_trunc_o) |-> dec_wide_o); // R10

    AST_BAD_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec_valid_o && dec_class_o == 3'b110) |-> dec_illegal_o); // R5

    AST_ATOM_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec_valid_o && dec_class_o == CL_STX && dec_mode_o == MD_ATOM &&
         (dec_size_o == 2'b01 || dec_size_o == 2'b10)) |-> dec_illegal_o); // R7

    AST_WIDE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec_valid_o && dec_wide_o) |->
        (dec_class_o == CL_LD && dec_mode_o == MD_IMM && dec_size_o == SZ_8)); // R8
endmodule

bind dual_endian_decoder ede_checker u_ede_checker (.*);

// File: tb/dual_endian_decoder_tb_top.sv
`timescale 1ns/1ps
module dual_endian_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        big_endian = 1'b0;
    logic        slot_valid = 1'b0;
    logic [63:0] slot_data = '0;
    logic        slot_last = 1'b0;
    logic        slot_ready;
    logic        dec_valid;
    logic        dec_ready = 1'b1;
    logic [2:0]  dec_class, dec_mode;
    logic [3:0]  dec_op, dec_dst, dec_src;
    logic        dec_srcsel, dec_wide, dec_illegal, dec_trunc;
    logic [1:0]  dec_size;
    logic [15:0] dec_off;
    logic [63:0] dec_imm;
    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dual_endian_decoder dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .big_endian_i(big_endian),
        .slot_valid_i(slot_valid), .slot_data_i(slot_data), .slot_last_i(slot_last),
        .slot_ready_o(slot_ready), .dec_valid_o(dec_valid), .dec_ready_i(dec_ready),
        .dec_class_o(dec_class), .dec_op_o(dec_op), .dec_srcsel_o(dec_srcsel),
        .dec_mode_o(dec_mode), .dec_size_o(dec_size), .dec_dst_o(dec_dst),
        .dec_src_o(dec_src), .dec_off_o(dec_off), .dec_imm_o(dec_imm),
        .dec_wide_o(dec_wide), .dec_illegal_o(dec_illegal), .dec_trunc_o(dec_trunc)
    );

    // encode a slot from intended fields, following R2/R3
    function automatic logic [63:0] mk(input logic be, input logic [7:0] code,
                                       input logic [3:0] dst, input logic [3:0] src,
                                       input logic [15:0] off, input logic [31:0] imm);
        logic [63:0] s;
        s[7:0]   = code;
        s[15:8]  = be ? {dst, src} : {src, dst};
        if (!be) begin
            s[23:16] = off[7:0];   s[31:24] = off[15:8];
            s[39:32] = imm[7:0];   s[47:40] = imm[15:8];
            s[55:48] = imm[23:16]; s[63:56] = imm[31:24];
        end else begin
            s[23:16] = off[15:8];  s[31:24] = off[7:0];
            s[39:32] = imm[31:24]; s[47:40] = imm[23:16];
            s[55:48] = imm[15:8];  s[63:56] = imm[7:0];
        end
        return s;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [63:0] s, input logic last);
        @(negedge clk);
        slot_valid = 1'b1; slot_data = s; slot_last = last;
        @(negedge clk);
        slot_valid = 1'b0; slot_last = 1'b0;
    endtask

    task automatic check_rec(input string tag, input logic [7:0] code, input logic [3:0] dst,
                             input logic [3:0] src, input logic [15:0] off, input logic [63:0] imm,
                             input logic wide, input logic ill, input logic tr);
        chk({tag, " valid"}, 64'(dec_valid), 64'd1);
        chk({tag, " class"}, 64'(dec_class), 64'(code[2:0]));
        chk({tag, " op"}, 64'(dec_op), 64'(code[7:4]));
        chk({tag, " srcsel"}, 64'(dec_srcsel), 64'(code[3]));
        chk({tag, " mode"}, 64'(dec_mode), 64'(code[7:5]));
        chk({tag, " size"}, 64'(dec_size), 64'(code[4:3]));
        chk({tag, " dst"}, 64'(dec_dst), 64'(dst));
        chk({tag, " src"}, 64'(dec_src), 64'(src));
        chk({tag, " off"}, 64'(dec_off), 64'(off));
        chk({tag, " imm"}, dec_imm, imm);
        chk({tag, " wide"}, 64'(dec_wide), 64'(wide));
        chk({tag, " illegal"}, 64'(dec_illegal), 64'(ill));
        chk({tag, " trunc"}, 64'(dec_trunc), 64'(tr));
    endtask

    task automatic chk_ill(input string tag, input logic [7:0] code, input logic exp);
        issue(mk(big_endian, code, 4'd1, 4'd2, 16'd0, 32'd0), 1'b0);
        chk({tag, " valid"}, 64'(dec_valid), 64'd1);
        chk({tag, " illegal"}, 64'(dec_illegal), 64'(exp));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", 64'(dec_valid), 64'd0);
        chk("R1 ready in reset", 64'(slot_ready), 64'd1);
        rst_ni = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", 64'(dec_valid), 64'd0);
        chk("R1 ready after reset", 64'(slot_ready), 64'd1);
    endtask

    task automatic t_little();
        big_endian = 1'b0;
        issue(mk(1'b0, 8'h07, 4'd3, 4'd9, 16'h8001, 32'hFFFF_FFF0), 1'b0);
        check_rec("R2 le neg", 8'h07, 4'd3, 4'd9, 16'h8001, 64'hFFFF_FFFF_FFFF_FFF0, 0, 0, 0);
        issue(mk(1'b0, 8'hBF, 4'd1, 4'd2, 16'h1234, 32'h1234_5678), 1'b0);
        check_rec("R2 R4 le mov", 8'hBF, 4'd1, 4'd2, 16'h1234, 64'h0000_0000_1234_5678, 0, 0, 0);
    endtask

    task automatic t_big();
        big_endian = 1'b1;
        issue(mk(1'b1, 8'h07, 4'd3, 4'd9, 16'h8001, 32'hFFFF_FFF0), 1'b0);
        check_rec("R3 be neg", 8'h07, 4'd3, 4'd9, 16'h8001, 64'hFFFF_FFFF_FFFF_FFF0, 0, 0, 0);
        // a little-endian encoded slot read in big-endian mode
        issue(mk(1'b0, 8'h61, 4'd3, 4'd9, 16'h1122, 32'h1122_3344), 1'b0);
        check_rec("R3 R4 be swap", 8'h61, 4'd9, 4'd3, 16'h2211, 64'h0000_0000_4433_2211, 0, 0, 0);
        big_endian = 1'b0;
    endtask

    task automatic t_illegal();
        chk_ill("R5 class110", 8'h06, 1'b1);
        chk_ill("R5 alu op E", 8'hE4, 1'b1);
        chk_ill("R5 alu64 op F", 8'hF7, 1'b1);
        chk_ill("R5 jmp exit", 8'h95, 1'b0);
        chk_ill("R5 alu op D", 8'hD4, 1'b0);
        chk_ill("R6 mode100", 8'h80, 1'b1);
        chk_ill("R6 mode101", 8'hA0, 1'b1);
        chk_ill("R6 mode111", 8'hE3, 1'b1);
        chk_ill("R6 ld abs", 8'h20, 1'b0);
        chk_ill("R6 ld ind", 8'h50, 1'b0);
        chk_ill("R6 st mem", 8'h62, 1'b0);
        chk_ill("R6 st abs", 8'h22, 1'b1);
        chk_ill("R6 ld imm w", 8'h00, 1'b1);
        chk_ill("R6 ldx ind", 8'h41, 1'b1);
    endtask

    task automatic t_atomic();
        chk_ill("R7 stx atom w", 8'hC3, 1'b0);
        chk_ill("R7 stx atom dw", 8'hDB, 1'b0);
        chk_ill("R7 stx atom h", 8'hCB, 1'b1);
        chk_ill("R7 stx atom b", 8'hD3, 1'b1);
        chk_ill("R7 ldx atom", 8'hC1, 1'b1);
    endtask

    task automatic t_wide();
        big_endian = 1'b0;
        issue(mk(1'b0, 8'h18, 4'd5, 4'd0, 16'h0000, 32'h89AB_CDEF), 1'b0);
        chk("R8 no record on first half", 64'(dec_valid), 64'd0);
        issue(mk(1'b0, 8'h00, 4'd0, 4'd0, 16'h0000, 32'h0123_4567), 1'b0);
        check_rec("R8 le merge", 8'h18, 4'd5, 4'd0, 16'h0, 64'h0123_4567_89AB_CDEF, 1, 0, 0);
        big_endian = 1'b1;
        issue(mk(1'b1, 8'h18, 4'hA, 4'd0, 16'h0000, 32'h7654_3210), 1'b0);
        chk("R8 be no record on first half", 64'(dec_valid), 64'd0);
        issue(mk(1'b1, 8'h00, 4'd0, 4'd0, 16'h0000, 32'hFEDC_BA98), 1'b0);
        check_rec("R8 be merge", 8'h18, 4'hA, 4'd0, 16'h0, 64'hFEDC_BA98_7654_3210, 1, 0, 0);
        big_endian = 1'b0;
        issue(mk(1'b0, 8'h18, 4'd2, 4'd0, 16'h0000, 32'h0000_0011), 1'b0);
        issue(mk(1'b0, 8'h00, 4'd0, 4'd0, 16'h0040, 32'h0000_0022), 1'b0);
        check_rec("R9 tail nonzero", 8'h18, 4'd2, 4'd0, 16'h0, 64'h0000_0022_0000_0011, 1, 1, 0);
    endtask

    task automatic t_trunc();
        big_endian = 1'b0;
        issue(mk(1'b0, 8'h18, 4'd7, 4'd0, 16'h0000, 32'h8000_0001), 1'b1);
        check_rec("R10 trunc", 8'h18, 4'd7, 4'd0, 16'h0, 64'hFFFF_FFFF_8000_0001, 1, 0, 1);
        issue(mk(1'b0, 8'h07, 4'd4, 4'd6, 16'h0003, 32'h0000_0005), 1'b0);
        check_rec("R10 after trunc", 8'h07, 4'd4, 4'd6, 16'h3, 64'h5, 0, 0, 0);
    endtask

    task automatic t_backpressure();
        @(negedge clk);
        dec_ready = 1'b0;
        issue(mk(1'b0, 8'h07, 4'd1, 4'd1, 16'h0, 32'h0000_00AA), 1'b0);
        chk("R11 record after accept", 64'(dec_valid), 64'd1);
        slot_valid = 1'b1;
        slot_data  = mk(1'b0, 8'h0F, 4'd2, 4'd3, 16'h0, 32'h0000_00BB);
        chk("R11 ready low when held", 64'(slot_ready), 64'd0);
        @(negedge clk);
        chk("R11 held valid", 64'(dec_valid), 64'd1);
        chk("R11 held imm", dec_imm, 64'hAA);
        chk("R11 ready still low", 64'(slot_ready), 64'd0);
        dec_ready = 1'b1;
        @(negedge clk);
        slot_valid = 1'b0;
        check_rec("R11 next taken on accept", 8'h0F, 4'd2, 4'd3, 16'h0, 64'hBB, 0, 0, 0);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_little();
        t_big();
        t_illegal();
        t_atomic();
        t_wide();
        t_trunc();
        t_backpressure();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule